// File: doc/BRIEF.md
# Per-frame control byte channel master

This block is the master end of a slow control channel carried in one timeslot of a time-division serial port. A CPU fills a shared 16-byte buffer and starts a transfer. The block then sends one byte in each 8 kHz frame, in the timeslot chosen by an address input. There is no acknowledge and no repeat. The line carries the idle value FF in every frame with nothing to send.

After the last byte leaves, the buffer changes to the receive direction. The block listens for the subscriber's answer, which starts no earlier than the next frame. Answer bytes equal to FF are idle filler and are dropped. Other answer bytes are stored for the CPU to read. The block returns to idle after a run of idle frames. If no answer byte arrived at all, it raises a timeout flag.

The port runs in one of two modes. In the first mode there are separate downstream and upstream lines, and the reply is taken from the same timeslot number. In the second mode one bidirectional line carries downstream slots in the first half of the frame and upstream slots in the second half, so the reply slot lies four slots after the transmit slot.

Top module: `mon_chan_ctrl`

## Requirements
- R1: After reset, fifo_count is 0, tx_done, rx_avail, timeout and wr_err are 0, and dd_byte is FF.
- R2: With no transfer in progress, dd_byte is FF in every cycle. dd_oe is high for exactly one cycle per frame, in the transmit slot.
- R3: A start taken in the last slot of a frame sends the buffered bytes in write order, one per frame, beginning in the next frame, each exactly once. tx_done pulses once, in the cycle after the slot of the last byte. At that point fifo_count reads 0, and later transmit slots carry FF.
- R4: With bidir_mode=0, the transmit and receive slots both equal target_slot. With bidir_mode=1, the transmit slot is target_slot mod 4 and the receive slot is (target_slot mod 4)+4. Slots are numbered 0 to 7 and slot 0 carries frame_sync.
- R5: Reply bytes are sampled only in receive slots of frames after the frame of the last transmitted byte. Values other than FF are stored in arrival order and set rx_avail. FF values are dropped.
- R6: Once a reply byte has been stored, reception continues each frame. It ends after IDLE_LIMIT (default 4) consecutive FF frames, with timeout left at 0.
- R7: If IDLE_LIMIT consecutive receive slots carry FF before any reply byte arrives, the block returns to idle and sets timeout. A taken start clears timeout.
- R8: A CPU write while waiting for or receiving a reply, or while the buffer is full, is discarded and sets wr_err. A taken start clears wr_err.
- R9: The buffer holds 16 bytes and fifo_count shows its fill level. rd_data shows the oldest byte, and rd_en removes it. rd_en is ignored while transmitting.
- R10: A start with an empty buffer is ignored: no byte is sent, no tx_done and no timeout follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per timeslot |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High in the slot-0 cycle of each frame |
| slot_valid | input | 1 | Current cycle is a timeslot |
| slot_idx | input | 3 | Number of the current timeslot |
| bidir_mode | input | 1 | 1: single bidirectional line, 0: separate lines |
| target_slot | input | 3 | Address of the subscriber timeslot |
| start | input | 1 | Begin a transfer (taken only when idle) |
| wr_en | input | 1 | CPU write strobe into the buffer |
| wr_data | input | 8 | CPU write byte |
| rd_en | input | 1 | CPU read strobe, removes the oldest byte |
| rd_data | output | 8 | Oldest byte in the buffer |
| du_byte | input | 8 | Upstream byte of the current slot |
| dd_byte | output | 8 | Downstream byte of the current slot |
| dd_oe | output | 1 | Drive enable for the transmit slot |
| fifo_count | output | 5 | Bytes held in the buffer |
| tx_done | output | 1 | One-cycle pulse after the last byte is sent |
| rx_avail | output | 1 | Received bytes are waiting to be read |
| timeout | output | 1 | No reply arrived within the idle limit |
| wr_err | output | 1 | A CPU write was refused |

## Verification
dd_byte and dd_oe are combinational in the slot cycle. The bench samples them one time unit after it drives the slot, in the same cycle. fifo_count, the flags and rd_data are registered and move at the edge that closes the stimulus cycle, so each of them is read in the following cycle. The reply script is indexed by frame number counted from the frame of the last transmitted byte. This lets a bench function predict the stored bytes and the timeout flag from the frame of the first answer and from the run of idle frames. The trap byte placed in the receive slot of the final transmit frame must never show up among the stored bytes.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_WAIT = 2'd2,
    ST_RX   = 2'd3
  } mcc_state_e;
endpackage

// File: rtl/mcc_fifo.sv
module mcc_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [CW-1:0] count_d;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (push) wr_ptr_d = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    if (push && !pop) count_d = count + 1'b1;
    else if (pop && !push) count_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  // R9: the sequencer never pushes into a full buffer without a pop
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (count < CW'(DEPTH)));
  // R9: the sequencer never pops an empty buffer
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/mcc_slot_sel.sv
module mcc_slot_sel #(
  parameter int SLOT_W = 3,
  localparam int LOW_W = SLOT_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_valid,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [SLOT_W-1:0] target_slot,
  input  logic              bidir_mode,
  output logic              tx_hit,
  output logic              rx_hit
);
  logic [SLOT_W-1:0] tx_slot, rx_slot;

  // Bidirectional line: down slots in the lower half, up slots in the upper half
  always_comb begin
    if (bidir_mode) begin
      tx_slot = {1'b0, target_slot[LOW_W-1:0]};
      rx_slot = {1'b1, target_slot[LOW_W-1:0]};
    end else begin
      tx_slot = target_slot;
      rx_slot = target_slot;
    end
  end

  assign tx_hit = slot_valid && (slot_idx == tx_slot);
  assign rx_hit = slot_valid && (slot_idx == rx_slot);

  // R4: on a shared line a slot is never both transmit and receive
  a_r4_disjoint_slots: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |-> !(tx_hit && rx_hit));
endmodule

// File: rtl/mcc_seq.sv
module mcc_seq
  import mcc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CW         = 5,
  parameter int IDLE_LIMIT = 4,
  localparam int IW = $clog2(IDLE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              frame_sync,
  input  logic              tx_hit,
  input  logic              rx_hit,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [CW-1:0]     count,
  input  logic              full,
  input  logic              empty,
  output logic              push,
  output logic              line_push,
  output logic              pop,
  output logic              tx_pop,
  output mcc_state_e        state,
  output logic              tx_done,
  output logic              timeout,
  output logic              wr_err,
  output logic              rx_dir
);
  mcc_state_e state_d;
  logic [IW-1:0] idle_cnt, idle_cnt_d;
  logic armed, armed_d;
  logic timeout_d, wr_err_d, rx_dir_d;
  logic cpu_wr_ok, cpu_rd_ok, rx_sample, rx_data_ok, rx_quiet, quiet_end;
  logic go_tx, go_wait;

  assign cpu_wr_ok  = wr_en && !full && (state == ST_IDLE || state == ST_TX);
  assign cpu_rd_ok  = rd_en && !empty && (state != ST_TX);
  assign rx_sample  = rx_hit && (armed || frame_sync) &&
                      (state == ST_WAIT || state == ST_RX);
  assign rx_data_ok = rx_sample && (rx_byte != {DATA_W{1'b1}});
  assign rx_quiet   = rx_sample && (rx_byte == {DATA_W{1'b1}});
  assign quiet_end  = rx_quiet && (idle_cnt == IW'(IDLE_LIMIT - 1));
  assign line_push  = rx_data_ok && !full;
  assign push       = cpu_wr_ok || line_push;
  assign tx_pop     = (state == ST_TX) && tx_hit && !empty;
  assign pop        = tx_pop || cpu_rd_ok;
  assign go_tx      = (state == ST_IDLE) && start && !empty;
  assign go_wait    = tx_pop && (count == CW'(1)) && !cpu_wr_ok;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (go_tx) state_d = ST_TX;
      ST_TX:   if (go_wait) state_d = ST_WAIT;
      ST_WAIT: if (rx_data_ok) state_d = ST_RX;
               else if (quiet_end) state_d = ST_IDLE;
      ST_RX:   if (quiet_end) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    idle_cnt_d = idle_cnt;
    if (go_wait || rx_data_ok) idle_cnt_d = '0;
    else if (rx_quiet) idle_cnt_d = idle_cnt + 1'b1;
    armed_d   = go_wait ? 1'b0 : (frame_sync ? 1'b1 : armed);
    timeout_d = go_tx ? 1'b0 : timeout;
    if (state == ST_WAIT && quiet_end && !rx_data_ok) timeout_d = 1'b1;
    wr_err_d  = go_tx ? 1'b0 : wr_err;
    if (wr_en && !cpu_wr_ok) wr_err_d = 1'b1;
    rx_dir_d  = go_tx ? 1'b0 : (rx_dir || line_push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idle_cnt <= '0;
      armed    <= 1'b0;
      tx_done  <= 1'b0;
      timeout  <= 1'b0;
      wr_err   <= 1'b0;
      rx_dir   <= 1'b0;
    end else begin
      state    <= state_d;
      idle_cnt <= idle_cnt_d;
      armed    <= armed_d;
      tx_done  <= go_wait;
      timeout  <= timeout_d;
      wr_err   <= wr_err_d;
      rx_dir   <= rx_dir_d;
    end
  end

  // R8: a write in the receive direction is always flagged
  a_r8_write_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (state == ST_WAIT || state == ST_RX)) |=> wr_err);
  // R7: the timeout flag only rises on the way back to idle
  a_r7_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (state == ST_IDLE));
  // R3: the done pulse coincides with the wait-for-reply state
  a_r3_done_waits: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (state == ST_WAIT));
  // R9: the buffer never empties by a CPU read while transmitting
  a_r9_no_read_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && !tx_hit) |=> $stable(count) || $past(wr_en));
endmodule

// File: rtl/mon_chan_ctrl.sv
module mon_chan_ctrl
  import mcc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 16,
  parameter int SLOT_W     = 3,
  parameter int IDLE_LIMIT = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              slot_valid,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic              bidir_mode,
  input  logic [SLOT_W-1:0] target_slot,
  input  logic              start,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] du_byte,
  output logic [DATA_W-1:0] dd_byte,
  output logic              dd_oe,
  output logic [CW-1:0]     fifo_count,
  output logic              tx_done,
  output logic              rx_avail,
  output logic              timeout,
  output logic              wr_err
);
  logic [1:0] rst_pipe;
  logic rst_sync_n;
  logic tx_hit, rx_hit, push, line_push, pop, tx_pop, full, empty, rx_dir;
  logic [DATA_W-1:0] fifo_din, fifo_dout;
  mcc_state_e state;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mcc_slot_sel #(.SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_sync_n), .slot_valid(slot_valid), .slot_idx(slot_idx),
    .target_slot(target_slot), .bidir_mode(bidir_mode),
    .tx_hit(tx_hit), .rx_hit(rx_hit)
  );

  mcc_seq #(.DATA_W(DATA_W), .CW(CW), .IDLE_LIMIT(IDLE_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .wr_en(wr_en), .rd_en(rd_en),
    .frame_sync(frame_sync), .tx_hit(tx_hit), .rx_hit(rx_hit), .rx_byte(du_byte),
    .count(fifo_count), .full(full), .empty(empty), .push(push),
    .line_push(line_push), .pop(pop), .tx_pop(tx_pop), .state(state),
    .tx_done(tx_done), .timeout(timeout), .wr_err(wr_err), .rx_dir(rx_dir)
  );

  assign fifo_din = line_push ? du_byte : wr_data;

  mcc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n), .push(push), .pop(pop), .din(fifo_din),
    .dout(fifo_dout), .count(fifo_count), .full(full), .empty(empty)
  );

  assign dd_byte  = tx_pop ? fifo_dout : {DATA_W{1'b1}};
  assign dd_oe    = tx_hit;
  assign rd_data  = fifo_dout;
  assign rx_avail = rx_dir && !empty;

  // R2: outside a transmission the downstream slot carries the idle value
  a_r2_idle_value: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dd_oe && state != ST_TX) |-> (dd_byte == {DATA_W{1'b1}}));
  // R3: after the done pulse the buffer has been drained
  a_r3_drained: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_done |-> (fifo_count == '0));
  // R5: received data is announced only while bytes are held
  a_r5_avail_nonempty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_avail |-> (fifo_count != '0));
endmodule

// File: tb/mon_chan_ctrl_bench.sv
module mon_chan_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE_LIM   = 4;
  localparam logic [7:0] IDLE = 8'hFF;
  localparam logic [7:0] TRAP = 8'h5A;

  logic clk = 1'b0;
  logic rst_n;
  logic frame_sync, slot_valid, bidir_mode, start, wr_en, rd_en;
  logic [2:0] slot_idx, target_slot;
  logic [7:0] wr_data, rd_data, du_byte, dd_byte;
  logic dd_oe, tx_done, rx_avail, timeout, wr_err;
  logic [4:0] fifo_count;

  int n_tests = 0;
  int n_fail  = 0;
  int cur_slot = 0;
  int frame_no = 0;
  int txd_cnt  = 0;
  int mon_f = 1 << 30;
  int mon_n = 0;
  logic [7:0] mon_tx [16];
  int rep_base = 1 << 30;
  logic [7:0] rep [8];
  logic [7:0] exp_rx [16];
  int exp_n;
  bit exp_to;
  int tx_slot_m = 0;
  int rx_slot_m = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mon_chan_ctrl u_mon_chan_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_valid(slot_valid),
    .slot_idx(slot_idx), .bidir_mode(bidir_mode), .target_slot(target_slot),
    .start(start), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .du_byte(du_byte), .dd_byte(dd_byte), .dd_oe(dd_oe),
    .fifo_count(fifo_count), .tx_done(tx_done), .rx_avail(rx_avail),
    .timeout(timeout), .wr_err(wr_err)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected reply capture and timeout from the reply script
  function automatic void model_rx();
    int idle_run;
    bit over;
    logic [7:0] b;
    idle_run = 0;
    over = 1'b0;
    exp_n = 0;
    exp_to = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (!over) begin
        b = (i < 8) ? rep[i] : IDLE;
        if (b != IDLE) begin
          exp_rx[exp_n] = b;
          exp_n++;
          idle_run = 0;
        end else begin
          idle_run++;
          if (idle_run == IDLE_LIM) begin
            over = 1'b1;
            exp_to = (exp_n == 0);
          end
        end
      end
    end
  endfunction

  function automatic logic [7:0] rand_data();
    return 8'($urandom_range(0, 254));
  endfunction

  // Advance one slot: drive at the falling edge, sample combinational outputs 1 unit later
  task automatic next_cycle();
    int idx;
    logic [7:0] exp_b;
    @(negedge clk);
    start = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    if (cur_slot == 0) frame_no++;
    slot_idx   = 3'(cur_slot);
    frame_sync = (cur_slot == 0);
    if (cur_slot == rx_slot_m && frame_no >= rep_base && frame_no < rep_base + 8)
      du_byte = rep[frame_no - rep_base];
    else if (cur_slot == rx_slot_m && frame_no == rep_base - 1)
      du_byte = TRAP;
    else
      du_byte = IDLE;
    #1;
    if (tx_done) txd_cnt++;
    // R4: drive enable only in the transmit slot
    if (dd_oe != (cur_slot == tx_slot_m)) chk("R4 dd_oe slot", int'(dd_oe), int'(cur_slot == tx_slot_m));
    if (dd_oe) begin
      idx = frame_no - mon_f;
      exp_b = (idx >= 0 && idx < mon_n) ? mon_tx[idx] : IDLE;
      chk((idx >= 0 && idx < mon_n) ? "R3 tx byte" : "R2 idle byte", int'(dd_byte), int'(exp_b));
    end
    cur_slot = (cur_slot + 1) % 8;
  endtask

  task automatic set_mode(bit bd, int t);
    bidir_mode = bd;
    target_slot = 3'(t);
    tx_slot_m = bd ? (t % 4) : t;
    rx_slot_m = bd ? (t % 4) + 4 : t;
  endtask

  task automatic xfer(bit bd, int t, int n, bit all_quiet);
    int last_f;
    set_mode(bd, t);
    next_cycle();
    for (int i = 0; i < n; i++) begin
      next_cycle();
      mon_tx[i] = rand_data();
      wr_en = 1'b1;
      wr_data = mon_tx[i];
    end
    if (n == 16) begin
      next_cycle();
      wr_en = 1'b1;
      wr_data = 8'h11;
    end
    next_cycle();
    chk("R9 count after writes", int'(fifo_count), n);
    if (n == 16) chk("R8 write into full buffer flagged", int'(wr_err), 1);
    for (int i = 0; i < 8; i++) rep[i] = all_quiet ? IDLE : (($urandom_range(0, 1) == 1) ? IDLE : rand_data());
    model_rx();
    while (cur_slot != 7) next_cycle();
    next_cycle();
    start = 1'b1;
    txd_cnt = 0;
    mon_f = frame_no + 1;
    mon_n = n;
    last_f = mon_f + n - 1;
    rep_base = last_f + 1;
    while (frame_no <= last_f + 13) begin
      next_cycle();
      if (frame_no == mon_f && cur_slot == 1) begin
        chk("R8 start clears wr_err", int'(wr_err), 0);
        rd_en = 1'b1;
      end
      if (frame_no == last_f + 1 && cur_slot == 1) begin
        chk("R3 count zero after last byte", int'(fifo_count), 0);
        wr_en = 1'b1;
        wr_data = 8'h22;
      end
    end
    next_cycle();
    chk("R3 single tx_done pulse", txd_cnt, 1);
    chk("R8 write while awaiting reply flagged", int'(wr_err), 1);
    chk(exp_to ? "R7 timeout set" : "R6 no timeout", int'(timeout), int'(exp_to));
    chk("R5 reply count", int'(fifo_count), exp_n);
    chk("R5 rx_avail", int'(rx_avail), int'(exp_n > 0));
    for (int i = 0; i < exp_n; i++) begin
      chk("R5 reply byte", int'(rd_data), int'(exp_rx[i]));
      rd_en = 1'b1;
      next_cycle();
    end
    next_cycle();
    chk("R9 empty after reads", int'(fifo_count), 0);
    chk("R5 rx_avail clears", int'(rx_avail), 0);
    rep_base = 1 << 30;
    mon_f = 1 << 30;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    frame_sync = 1'b0;
    slot_valid = 1'b1;
    slot_idx = '0;
    start = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    wr_data = '0;
    du_byte = IDLE;
    set_mode(1'b0, 2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) next_cycle();
    // R1: reset state
    chk("R1 count", int'(fifo_count), 0);
    chk("R1 tx_done", int'(tx_done), 0);
    chk("R1 rx_avail", int'(rx_avail), 0);
    chk("R1 timeout", int'(timeout), 0);
    chk("R1 wr_err", int'(wr_err), 0);
    chk("R1 dd_byte", int'(dd_byte), int'(IDLE));
    // R2: idle frames carry FF (checked by the slot monitor)
    repeat (16) next_cycle();
    // R10: start with an empty buffer does nothing
    txd_cnt = 0;
    while (cur_slot != 7) next_cycle();
    next_cycle();
    start = 1'b1;
    repeat (48) next_cycle();
    chk("R10 no tx_done on empty start", txd_cnt, 0);
    chk("R10 no timeout on empty start", int'(timeout), 0);
    // Directed corners
    xfer(1'b0, 0, 3, 1'b0);
    xfer(1'b0, 7, 2, 1'b0);
    xfer(1'b1, 6, 1, 1'b1);
    xfer(1'b1, 3, 16, 1'b0);
    xfer(1'b0, 5, 2, 1'b1);
    // Random transfers
    for (int k = 0; k < 8; k++)
      xfer(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), int'($urandom_range(1, 6)), 1'b0);
    summary();
  end
endmodule